// File: doc/BRIEF.md
# Two-Stage Watchdog Timer Controller

The block counts system clocks from the last software restart. When the selected interval runs out it raises an interrupt flag, giving software a first warning. If software still does not restart the count, a one-cycle system reset request follows a fixed grace period later. Software can turn the reset stage off, and the counter keeps running in that case, so the block still works as a periodic interrupt source.

Software reaches the block through a small register port made of an address, write data, a write strobe and a combinational read path. The bits that arm the reset stage, change the interrupt flag or restart the count are guarded by a timed unlock. Software must write a two-byte key to a key register and then make its protected write within a short window. This makes it very unlikely that runaway code can disarm or feed the watchdog.

A power-on reset through `rst_ni` returns everything to its idle, disarmed state. A reset that the watchdog raises itself leaves the reset stage armed and the interval selection unchanged. It clears the interrupt flag, records the reset cause and restarts the count from zero.

Top module: `wdt_ctrl`

## Requirements
- R1: The interval field sits in bits 1:0 of the mode register at address 1 and resets to 00. Value m sets the interrupt flag exactly 2^(EXP0+STEP*m) clocks after the clock edge that restarted the count (with defaults 2^17, 2^20, 2^23, 2^26).
- R2: irq_o is high exactly when the interrupt flag is set and irq_en_i is high.
- R3: With reset-enable set and no restart, wdt_rst_o goes high GRACE clocks (default 512) after the interrupt point, for exactly one cycle.
- R4: A protected write to the control register (address 0) with bit 0 set restarts the count from zero, which delays both the flag and the reset. Bit 0 always reads 0.
- R5: With reset-enable (control bit 1) clear, no reset is requested, the count keeps running, the flag still sets, and the reset-cause flag stays 0.
- R6: The reset-cause flag (control bit 2) sets on every watchdog reset. It is cleared only by a control write with bit 2 at 0, which needs no unlock, or by rst_ni. Writing 1 to it never sets it.
- R7: On a watchdog reset the count restarts from zero and the interrupt flag clears. Reset-enable and the mode field keep their values, so the next flag follows one full interval after the reset pulse.
- R8: After rst_ni the control register reads 0 (disarmed, no flags) and the mode field reads 00.
- R9: Control bits 3 (interrupt flag), 1 (reset-enable) and 0 (restart) change only through a control write made while the unlock window is open. Such a write loads bits 3 and 1 directly.
- R10: Writing 0xAA and then 0x55 to the key register (address 2) on back-to-back clocks opens the window for WIN clocks (default 4). Any other order leaves it shut. The first control write made inside the window closes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on/power-fail reset |
| addr_i | input | 2 | Register address: 0 control, 1 mode, 2 key |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, one write per clock |
| irq_en_i | input | 1 | Interrupt enable from the interrupt controller |
| rdata_o | output | 8 | Read data for addr_i |
| irq_o | output | 1 | Interrupt request |
| wdt_rst_o | output | 1 | One-cycle watchdog reset request |

## Verification
The bench measures the exact clock count from a restart to the interrupt flag and to the reset pulse, for every interval with the reset stage on and off. An off-by-one in the limit compare, or a grace period counted from the wrong point, shows up as a shifted cycle number. It also checks that the interval after a watchdog reset is a full interval. A design that skipped clearing the counter, or that disarmed itself on its own reset, would fire early or never fire again. It sweeps how many idle clocks pass between the unlock and the protected write, and tries broken key orders and a second write in one window. A window that is one cycle too long or too short, or that stays open after use, lets a write through that should be ignored. It also checks that the reset-cause flag cannot be set by software and survives a restart, and that irq_o follows the enable input.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CTL_W  = 4;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_KEY  = 2'd2;

  localparam logic [DATA_W-1:0] KEY_FIRST  = 8'hAA;
  localparam logic [DATA_W-1:0] KEY_SECOND = 8'h55;

  localparam int unsigned BIT_IFLAG   = 3;
  localparam int unsigned BIT_RCAUSE  = 2;
  localparam int unsigned BIT_RSTEN   = 1;
  localparam int unsigned BIT_RESTART = 0;

  typedef enum logic {UL_IDLE, UL_ARMED} unlock_e;
endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
  import wdt_pkg::*;
#(
  parameter int unsigned WIN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              key_we_i,
  input  logic              ctl_we_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              open_o
);
  localparam int unsigned WIN_W = $clog2(WIN + 1);

  unlock_e          state_q;
  logic [WIN_W-1:0] win_q;
  logic             seq_ok;

  assign seq_ok = (state_q == UL_ARMED) && key_we_i && (data_i == KEY_SECOND);
  assign open_o = (win_q != '0);

  // first key byte must be followed on the very next clock by the second
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= UL_IDLE;
    end else if (abort_i) begin
      state_q <= UL_IDLE;
    end else begin
      state_q <= (key_we_i && data_i == KEY_FIRST) ? UL_ARMED : UL_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
    end else if (abort_i) begin
      win_q <= '0;
    end else if (seq_ok) begin
      win_q <= WIN_W'(WIN);
    end else if (ctl_we_i && open_o) begin
      win_q <= '0;
    end else if (open_o) begin
      win_q <= win_q - WIN_W'(1);
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned EXP0  = 17,
  parameter int unsigned STEP  = 3,
  parameter int unsigned GRACE = 512,
  parameter int unsigned CNT_W = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             rst_en_i,
  input  logic [1:0]       mode_i,
  output logic             int_hit_o,
  output logic             fire_o,
  output logic             pulse_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] GRC_C = CNT_W'(GRACE);

  logic [CNT_W-1:0] lim_tbl [4];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] int_lim;
  logic [CNT_W-1:0] rst_lim;
  logic             pulse_q;

  for (genvar m = 0; m < 4; m++) begin : g_lim
    localparam int unsigned EXP_M = EXP0 + m * STEP;
    assign lim_tbl[m] = ONE << EXP_M;
  end

  assign int_lim   = lim_tbl[mode_i];
  assign rst_lim   = int_lim + GRC_C;
  assign int_hit_o = !clear_i && (cnt_q == int_lim - ONE);
  assign fire_o    = !clear_i && rst_en_i && (cnt_q == rst_lim - ONE);
  assign pulse_o   = pulse_q;
  assign cnt_o     = cnt_q;

  // free-running when reset stage is off; wraps at 2^CNT_W
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= fire_o;
      if (clear_i || fire_o) cnt_q <= '0;
      else                   cnt_q <= cnt_q + ONE;
    end
  end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CTL_W-1:0]  wdata_i,
  input  logic              open_i,
  input  logic              int_hit_i,
  input  logic              fire_i,
  output logic              iflag_o,
  output logic              rcause_o,
  output logic              rst_en_o,
  output logic [1:0]        mode_o,
  output logic              restart_o,
  output logic              ctl_we_o,
  output logic              key_we_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic iflag_q, rcause_q, rst_en_q;
  logic [1:0] mode_q;
  logic prot_ok;

  assign ctl_we_o  = we_i && (addr_i == ADDR_CTRL);
  assign key_we_o  = we_i && (addr_i == ADDR_KEY);
  assign prot_ok   = ctl_we_o && open_i;
  assign restart_o = prot_ok && wdata_i[BIT_RESTART];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iflag_q  <= 1'b0;
      rcause_q <= 1'b0;
      rst_en_q <= 1'b0;
      mode_q   <= 2'b00;
    end else begin
      // hardware events win over software in the same cycle
      if (fire_i)         iflag_q <= 1'b0;
      else if (int_hit_i) iflag_q <= 1'b1;
      else if (prot_ok)   iflag_q <= wdata_i[BIT_IFLAG];

      if (fire_i)                                rcause_q <= 1'b1;
      else if (ctl_we_o && !wdata_i[BIT_RCAUSE]) rcause_q <= 1'b0;

      if (prot_ok) rst_en_q <= wdata_i[BIT_RSTEN];

      if (we_i && addr_i == ADDR_MODE) mode_q <= wdata_i[1:0];
    end
  end

  assign iflag_o  = iflag_q;
  assign rcause_o = rcause_q;
  assign rst_en_o = rst_en_q;
  assign mode_o   = mode_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: begin
        rdata_o[BIT_IFLAG]  = iflag_q;
        rdata_o[BIT_RCAUSE] = rcause_q;
        rdata_o[BIT_RSTEN]  = rst_en_q;
      end
      ADDR_MODE: rdata_o[1:0] = mode_q;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int unsigned EXP0  = 17,
  parameter int unsigned STEP  = 3,
  parameter int unsigned GRACE = 512,
  parameter int unsigned WIN   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              irq_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              wdt_rst_o
);
  localparam int unsigned MAX_EXP = EXP0 + 3 * STEP;
  localparam int unsigned CNT_W   = MAX_EXP + 1;

  logic             ta_open, ctl_we, key_we, restart, fire, int_hit;
  logic             iflag, rcause, rst_en;
  logic [1:0]       mode;
  logic [CNT_W-1:0] cnt;

  wdt_unlock #(.WIN(WIN)) u_unlock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .abort_i  (fire),
    .key_we_i (key_we),
    .ctl_we_i (ctl_we),
    .data_i   (wdata_i),
    .open_o   (ta_open)
  );

  wdt_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i[CTL_W-1:0]),
    .open_i    (ta_open),
    .int_hit_i (int_hit),
    .fire_i    (fire),
    .iflag_o   (iflag),
    .rcause_o  (rcause),
    .rst_en_o  (rst_en),
    .mode_o    (mode),
    .restart_o (restart),
    .ctl_we_o  (ctl_we),
    .key_we_o  (key_we),
    .rdata_o   (rdata_o)
  );

  wdt_counter #(
    .EXP0 (EXP0),
    .STEP (STEP),
    .GRACE(GRACE),
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (restart),
    .rst_en_i  (rst_en),
    .mode_i    (mode),
    .int_hit_o (int_hit),
    .fire_o    (fire),
    .pulse_o   (wdt_rst_o),
    .cnt_o     (cnt)
  );

  assign irq_o = iflag && irq_en_i;
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 27
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              irq_en_i,
  input logic              irq_o,
  input logic              wdt_rst_o,
  input logic              ta_open,
  input logic              restart,
  input logic              iflag,
  input logic              rcause,
  input logic              rst_en,
  input logic [CNT_W-1:0]  cnt
);
  assert_irq_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o);

  assert_single_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o);

  assert_restart_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(restart) |-> (cnt == '0));

  assert_no_rst_disarmed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> rst_en);

  assert_cause_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rcause) |-> wdt_rst_o);

  assert_wdrst_effects_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> (cnt == '0 && !iflag));

  assert_guarded_rsten_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rst_en) |-> $past(ta_open && we_i && addr_i == ADDR_CTRL));

  assert_window_single_use_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ta_open && we_i && addr_i == ADDR_CTRL) |-> !ta_open);
endmodule

bind wdt_ctrl wdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .irq_en_i  (irq_en_i),
  .irq_o     (irq_o),
  .wdt_rst_o (wdt_rst_o),
  .ta_open   (ta_open),
  .restart   (restart),
  .iflag     (iflag),
  .rcause    (rcause),
  .rst_en    (rst_en),
  .cnt       (cnt)
);

// File: tb/sim_wdt_ctrl.sv
`timescale 1ns/1ps
module sim_wdt_ctrl;
  localparam int EXP0 = 4, STEP = 1, GRACE = 8, WIN = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       we_i = 1'b0;
  logic       irq_en_i = 1'b1;
  logic [7:0] rdata_o;
  logic       irq_o, wdt_rst_o;

  int n_chk = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  wdt_ctrl #(.EXP0(EXP0), .STEP(STEP), .GRACE(GRACE), .WIN(WIN)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .irq_en_i(irq_en_i), .rdata_o(rdata_o), .irq_o(irq_o),
    .wdt_rst_o(wdt_rst_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0; addr_i = 2'd0; wdata_i = '0;
  endtask

  task automatic unlock();
    wr(2'd2, 8'hAA);
    wr(2'd2, 8'h55);
  endtask

  task automatic pwr(input logic [7:0] d);
    unlock();
    wr(2'd0, d);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr_i = a; #1; d = rdata_o; addr_i = 2'd0; #1;
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    do_reset();
    // R8 reset state
    rd(2'd0, d); chk("R8 ctrl after reset", d, 0);
    rd(2'd1, d); chk("R1 mode after reset", d, 0);
    chk("R8 no reset pulse", wdt_rst_o, 0);
    chk("R2 irq idle", irq_o, 0);

    // R9 writes without unlock are ignored
    wr(2'd0, 8'h0A);
    rd(2'd0, d); chk("R9 unguarded write ignored", d & 8'h0A, 0);

    // R10 broken key sequences
    wr(2'd2, 8'hAA); @(negedge clk_i); wr(2'd2, 8'h55); wr(2'd0, 8'h03);
    rd(2'd0, d); chk("R10 gap between keys", d[1], 0);
    wr(2'd2, 8'hAA); wr(2'd1, 8'h00); wr(2'd2, 8'h55); wr(2'd0, 8'h03);
    rd(2'd0, d); chk("R10 foreign write between keys", d[1], 0);
    wr(2'd2, 8'h55); wr(2'd2, 8'hAA); wr(2'd0, 8'h03);
    rd(2'd0, d); chk("R10 reversed keys", d[1], 0);

    // R10 window length sweep
    for (int k = 0; k <= WIN + 1; k++) begin
      unlock();
      repeat (k) @(negedge clk_i);
      wr(2'd0, 8'h03);
      rd(2'd0, d);
      chk($sformatf("R10 window idle=%0d", k), d[1], (k < WIN) ? 1 : 0);
      pwr(8'h05);
      rd(2'd0, d); chk("R9 disarm via unlock", d[1], 0);
    end

    // R10 window closes after one protected write
    unlock(); wr(2'd0, 8'h01); wr(2'd0, 8'h03);
    rd(2'd0, d); chk("R10 second write in window", d[1], 0);

    // R1/R3/R5/R6/R7 interval sweep
    for (int m = 0; m < 4; m++) begin
      for (int en = 1; en >= 0; en--) begin
        int lim, r1, r2, np, pc, prev;
        logic fl_p, rc_p;
        lim = 1 << (EXP0 + m * STEP);
        r1 = -1; r2 = -1; np = -1; pc = 0; prev = 0; fl_p = 1'b1; rc_p = 1'b0;
        wr(2'd1, 8'(m));
        pwr(en ? 8'h07 : 8'h05);  // keeps rcause, restarts, sets reset-enable
        for (int n = 1; n <= 2 * lim + GRACE + 1; n++) begin
          @(negedge clk_i);
          if (rdata_o[3] && !prev) begin
            if (r1 < 0) r1 = n; else if (r2 < 0) r2 = n;
          end
          prev = rdata_o[3];
          if (wdt_rst_o) begin
            pc++;
            if (np < 0) begin np = n; fl_p = rdata_o[3]; rc_p = rdata_o[2]; end
          end
        end
        chk($sformatf("R1 flag point mode=%0d en=%0d", m, en), r1, lim);
        if (en) begin
          chk($sformatf("R3 pulse point mode=%0d", m), np, lim + GRACE);
          chk($sformatf("R3 pulse count mode=%0d", m), pc, 1);
          chk($sformatf("R7 flag cleared by wd reset mode=%0d", m), fl_p, 0);
          chk($sformatf("R6 cause set mode=%0d", m), rc_p, 1);
          chk($sformatf("R7 full interval after wd reset mode=%0d", m), r2, 2 * lim + GRACE);
          rd(2'd0, d); chk("R7 reset-enable kept", d[1], 1);
          pwr(8'h05);
          rd(2'd0, d); chk("R6 cause survives restart", d[2], 1);
          rd(2'd1, d); chk("R7 mode kept", d, m);
          wr(2'd0, 8'h04);
          rd(2'd0, d); chk("R6 write 1 keeps cause", d[2], 1);
          wr(2'd0, 8'h00);
          rd(2'd0, d); chk("R6 cause cleared by write", d[2], 0);
          wr(2'd0, 8'h04);
          rd(2'd0, d); chk("R6 write 1 cannot set cause", d[2], 0);
        end else begin
          chk($sformatf("R5 no pulse mode=%0d", m), pc, 0);
          rd(2'd0, d);
          chk($sformatf("R5 flag held mode=%0d", m), d[3], 1);
          chk($sformatf("R5 cause stays 0 mode=%0d", m), d[2], 0);
          // R2 gating
          irq_en_i = 1'b0; #1; chk("R2 masked", irq_o, 0);
          irq_en_i = 1'b1; #1; chk("R2 asserted", irq_o, 1);
          wr(2'd0, 8'h00);
          rd(2'd0, d); chk("R9 flag clear needs unlock", d[3], 1);
          pwr(8'h00);
          chk("R2 deasserts after clear", irq_o, 0);
          pwr(8'h08);
          chk("R9 flag set by guarded write", irq_o, 1);
          pwr(8'h01);
        end
      end
    end

    // R4 periodic restart defers flag and reset
    wr(2'd1, 8'h00);
    pwr(8'h03);
    begin
      int seen_f, seen_p;
      seen_f = 0; seen_p = 0;
      for (int r = 0; r < 6; r++) begin
        repeat (9) begin
          @(negedge clk_i);
          if (rdata_o[3]) seen_f++;
          if (wdt_rst_o) seen_p++;
        end
        pwr(8'h03);
      end
      chk("R4 restarts hold off flag", seen_f, 0);
      chk("R4 restarts hold off reset", seen_p, 0);
    end
    rd(2'd0, d); chk("R4 restart bit reads 0", d[0], 0);

    // R8 power-on reset disarms and clears
    wr(2'd1, 8'h02);
    do_reset();
    rd(2'd0, d); chk("R8 ctrl cleared by rst_ni", d, 0);
    rd(2'd1, d); chk("R8 mode cleared by rst_ni", d, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule